// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block performs 32-bit integer arithmetic that clamps to the limit of the result range instead of wrapping, and keeps a sticky flag that records whether any clamp has happened. Each cycle an opcode selects one operation on two operands, `a_i` and `b_i`. The saturate-to-N operations also take a 5-bit bit position `pos_i`. The result and the sticky flag are registered, so an operation presented before a rising edge is visible on the outputs after that edge.

The available operations are:
- signed add and signed subtract;
- an add that only records overflow and returns the wrapped sum;
- signed doubling;
- signed double-then-add;
- unsigned add and unsigned subtract;
- signed and unsigned clamping of operand `a_i` to a chosen bit position, in a full-width form and a two-lane 16-bit form.

Opcode 0 is an idle code. Software-visible state is limited to the sticky flag. The flag is set only by a clamping operation and cleared only through `clr_i`.

Top module: `sat_alu`

## Requirements
- R1: After reset (`rst_ni` low), `result_o` reads 0 and `sticky_o` reads 0.
- R2: Opcode 1 (signed add) yields a+b, clamped to 0x7FFFFFFF when a is non-negative and to 0x80000000 when a is negative, whenever a and b share a sign and the sum's sign differs from a's. A clamp sets the sticky flag.
- R3: Opcode 2 (signed subtract) yields a-b, clamped to 0x7FFFFFFF or 0x80000000 by the sign of a, whenever a and b differ in sign and the difference's sign differs from a's. A clamp sets the sticky flag.
- R4: Opcode 3 (overflow-recording add) always yields the wrapped 32-bit sum a+b, and sets the sticky flag under the same overflow condition as R2.
- R5: Opcode 4 (signed double of b) yields 0x7FFFFFFF for b >= 0x40000000 and 0x80000000 for signed b <= 0xC0000000, setting the sticky flag in both cases. Otherwise it yields b shifted left by one.
- R6: Opcode 5 (double-then-add) yields the signed add of R2 applied to a and the doubled b of R5. The sticky flag is set if either step clamps.
- R7: Opcode 6 (unsigned add) yields 0xFFFFFFFF on carry out of bit 31. Opcode 7 (unsigned subtract) yields 0 when b > a. Both set the sticky flag when they clamp.
- R8: Opcode 8 clamps signed a to the range -(2^s) to 2^s-1, where s is `pos_i`, and sets the sticky flag when the value changes.
- R9: Opcode 9 clamps signed a to the range 0 to 2^s-1, and sets the sticky flag when the value changes.
- R10: Opcodes 10 (signed) and 11 (unsigned) apply the clamp of R8 or R9 separately to the sign-extended bits [15:0] and bits [31:16] of a. The two 16-bit results are packed into the same halves of the result, and the sticky flag is set if either lane clamps.
- R11: The sticky flag stays set until `clr_i` is high at a rising edge. `clr_i` clears it even when a clamping operation is issued in the same cycle, and the result of that operation is still delivered.
- R12: Opcode 0, and the unused codes 12 to 15, leave both the result and the sticky flag unchanged, apart from a clear requested by `clr_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand; also the value for the clamp operations |
| b_i | input | 32 | Second operand |
| pos_i | input | 5 | Saturation bit position s |
| clr_i | input | 1 | Clears the sticky flag |
| result_o | output | 32 | Registered result |
| sticky_o | output | 1 | Sticky saturation flag |

## Verification
A clear request and a clamping operation can fall in the same cycle and compete for the sticky flag. The bench issues a saturating signed add with `clr_i` high. It then expects the clamped value on `result_o` and a low `sticky_o`, because the clear must win while the result is still delivered. Apart from that case, every swept vector is followed by an idle cycle with `clr_i` high. That cycle confirms the clear and checks that the idle code holds the result. A separate sequence checks that a later operation that does not clamp leaves the flag set.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    typedef enum logic [3:0] {
        OP_IDLE     = 4'd0,
        OP_SADD     = 4'd1,
        OP_SSUB     = 4'd2,
        OP_SADD_REC = 4'd3,
        OP_SDBL     = 4'd4,
        OP_SDBL_ADD = 4'd5,
        OP_UADD     = 4'd6,
        OP_USUB     = 4'd7,
        OP_SCLAMP   = 4'd8,
        OP_UCLAMP   = 4'd9,
        OP_SCLAMP2  = 4'd10,
        OP_UCLAMP2  = 4'd11
    } sat_op_e;

endpackage

// File: rtl/sat_arith.sv
// Add/subtract/double datapath with signed and unsigned limiting.
module sat_arith
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  sat_op_e            op_i,
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    output logic [DATA_W-1:0]  res_o,
    output logic               sat_o
);
    localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] UMAX = {DATA_W{1'b1}};

    logic [DATA_W-1:0] sum_d, diff_d, dbl_d, qsum_d;
    logic [DATA_W:0]   usum_d, udiff_d;
    logic              sum_ov_d, diff_ov_d, dbl_hi_d, dbl_lo_d, qsum_ov_d;
    logic [DATA_W-1:0] a_clamp_d;

    always_comb begin
        // signed sum / difference overflow
        sum_d     = a_i + b_i;
        sum_ov_d  = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (sum_d[DATA_W-1] != a_i[DATA_W-1]);
        diff_d    = a_i - b_i;
        diff_ov_d = (a_i[DATA_W-1] != b_i[DATA_W-1]) && (diff_d[DATA_W-1] != a_i[DATA_W-1]);
        a_clamp_d = a_i[DATA_W-1] ? SMIN : SMAX;

        // doubling of b: upper threshold 2^(W-2), lower threshold -(2^(W-2)) inclusive
        dbl_hi_d = !b_i[DATA_W-1] && b_i[DATA_W-2];
        dbl_lo_d = b_i[DATA_W-1] && (!b_i[DATA_W-2] || (b_i[DATA_W-3:0] == '0));
        if (dbl_hi_d) begin
            dbl_d = SMAX;
        end else if (dbl_lo_d) begin
            dbl_d = SMIN;
        end else begin
            dbl_d = {b_i[DATA_W-2:0], 1'b0};
        end

        // add of a and doubled b
        qsum_d    = a_i + dbl_d;
        qsum_ov_d = (a_i[DATA_W-1] == dbl_d[DATA_W-1]) && (qsum_d[DATA_W-1] != a_i[DATA_W-1]);

        // unsigned with carry/borrow
        usum_d  = {1'b0, a_i} + {1'b0, b_i};
        udiff_d = {1'b0, a_i} - {1'b0, b_i};

        res_o = '0;
        sat_o = 1'b0;
        unique case (op_i)
            OP_SADD: begin
                res_o = sum_ov_d ? a_clamp_d : sum_d;
                sat_o = sum_ov_d;
            end
            OP_SSUB: begin
                res_o = diff_ov_d ? a_clamp_d : diff_d;
                sat_o = diff_ov_d;
            end
            OP_SADD_REC: begin
                res_o = sum_d;
                sat_o = sum_ov_d;
            end
            OP_SDBL: begin
                res_o = dbl_d;
                sat_o = dbl_hi_d || dbl_lo_d;
            end
            OP_SDBL_ADD: begin
                res_o = qsum_ov_d ? a_clamp_d : qsum_d;
                sat_o = qsum_ov_d || dbl_hi_d || dbl_lo_d;
            end
            OP_UADD: begin
                res_o = usum_d[DATA_W] ? UMAX : usum_d[DATA_W-1:0];
                sat_o = usum_d[DATA_W];
            end
            OP_USUB: begin
                res_o = udiff_d[DATA_W] ? '0 : udiff_d[DATA_W-1:0];
                sat_o = udiff_d[DATA_W];
            end
            default: begin
                res_o = '0;
                sat_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sat_clamp.sv
// Clamps a signed value of IN_W bits to a bit position, signed or unsigned range.
module sat_clamp #(
    parameter int DATA_W = 32,
    parameter int IN_W   = 32,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic [IN_W-1:0]  val_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             uns_i,
    output logic [IN_W-1:0]  val_o,
    output logic             sat_o
);
    localparam int CW = DATA_W + 2;

    logic signed [CW-1:0] ext_d, lim_d, hi_d, lo_d, clamped_d;

    always_comb begin
        ext_d = {{(CW-IN_W){val_i[IN_W-1]}}, val_i};
        lim_d = {{(CW-1){1'b0}}, 1'b1} << pos_i;
        hi_d  = lim_d - 1;
        lo_d  = uns_i ? '0 : -lim_d;

        clamped_d = ext_d;
        sat_o     = 1'b0;
        if (ext_d > hi_d) begin
            clamped_d = hi_d;
            sat_o     = 1'b1;
        end else if (ext_d < lo_d) begin
            clamped_d = lo_d;
            sat_o     = 1'b1;
        end
        val_o = clamped_d[IN_W-1:0];
    end

endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = 2,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] result_o,
    output logic              sticky_o
);
    localparam int LANE_W = DATA_W / LANES;
    localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              sticky;
    } state_t;

    state_t  state_d, state_q;
    sat_op_e op;
    logic    uns_sel;

    assign op      = sat_op_e'(op_i);
    assign uns_sel = (op == OP_UCLAMP) || (op == OP_UCLAMP2);

    // arithmetic datapath
    logic [DATA_W-1:0] arith_res;
    logic              arith_sat;

    sat_arith #(.DATA_W(DATA_W)) u_arith (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (arith_res),
        .sat_o (arith_sat)
    );

    // full-width clamp
    logic [DATA_W-1:0] full_res;
    logic              full_sat;

    sat_clamp #(.DATA_W(DATA_W), .IN_W(DATA_W), .POS_W(POS_W)) u_full (
        .val_i (a_i),
        .pos_i (pos_i),
        .uns_i (uns_sel),
        .val_o (full_res),
        .sat_o (full_sat)
    );

    // per-lane clamps
    logic [DATA_W-1:0] lane_res;
    logic [LANES-1:0]  lane_sat;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sat_clamp #(.DATA_W(DATA_W), .IN_W(LANE_W), .POS_W(POS_W)) u_lane (
            .val_i (a_i[g*LANE_W +: LANE_W]),
            .pos_i (pos_i),
            .uns_i (uns_sel),
            .val_o (lane_res[g*LANE_W +: LANE_W]),
            .sat_o (lane_sat[g])
        );
    end

    logic sat_d;

    always_comb begin
        state_d = state_q;
        sat_d   = 1'b0;
        unique case (op)
            OP_SADD, OP_SSUB, OP_SADD_REC, OP_SDBL, OP_SDBL_ADD, OP_UADD, OP_USUB: begin
                state_d.result = arith_res;
                sat_d          = arith_sat;
            end
            OP_SCLAMP, OP_UCLAMP: begin
                state_d.result = full_res;
                sat_d          = full_sat;
            end
            OP_SCLAMP2, OP_UCLAMP2: begin
                state_d.result = lane_res;
                sat_d          = |lane_sat;
            end
            default: begin
                sat_d = 1'b0;
            end
        endcase
        // clear has priority over any set in the same cycle
        state_d.sticky = clr_i ? 1'b0 : (state_q.sticky || sat_d);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign sticky_o = state_q.sticky;

    // R11: clear wins over a same-cycle set
    p_clear_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !sticky_o);

    // R11: the flag never drops without a clear
    p_sticky_keeps_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sticky_o && !clr_i) |=> sticky_o);

    // R12: idle code holds both outputs
    p_idle_holds_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd0 && !clr_i) |=> ($stable(result_o) && $stable(sticky_o)));

    // R4: recording add returns the wrapped sum
    p_rec_wraps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd3) |=> (result_o == $past(a_i + b_i)));

    // R7: unsigned subtract floors at zero when b exceeds a
    p_usub_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd7 && a_i < b_i && !clr_i) |=> (result_o == '0 && sticky_o));

    // R2: positive overflow of the signed add gives the top value
    p_sadd_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd1 && !a_i[DATA_W-1] && !b_i[DATA_W-1] && (a_i + b_i) >= {1'b1, {(DATA_W-1){1'b0}}})
        |=> (result_o == SMAX));

    // R8: position 0 signed clamp leaves only 0 or -1
    p_sclamp_pos0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd8 && pos_i == '0) |=> (result_o == '0 || result_o == '1));

endmodule

// File: tb/test_sat_alu.sv
module test_sat_alu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op;
    logic [31:0] a, b;
    logic [4:0]  pos;
    logic        clr;
    logic [31:0] result;
    logic        sticky;

    always #2 clk = ~clk;

    sat_alu i_sat_alu (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .pos_i    (pos),
        .clr_i    (clr),
        .result_o (result),
        .sticky_o (sticky)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] corners [16] = '{
        32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
        32'h8000_0000, 32'h4000_0000, 32'h3FFF_FFFF, 32'hC000_0000,
        32'hC000_0001, 32'hBFFF_FFFF, 32'h0000_7FFF, 32'hFFFF_8000,
        32'h1234_5678, 32'h8765_4321, 32'h0001_0000, 32'h7FFF_8001
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // reference models with wide arithmetic
    function automatic logic [31:0] ref_s(input longint v, input int s, output bit sat);
        longint hi = (longint'(1) <<< s) - 1;
        longint lo = -(longint'(1) <<< s);
        sat = 1'b0;
        if (v > hi) begin v = hi; sat = 1'b1; end
        else if (v < lo) begin v = lo; sat = 1'b1; end
        return v[31:0];
    endfunction

    function automatic logic [31:0] ref_u(input longint v, input int s, output bit sat);
        longint hi = (longint'(1) <<< s) - 1;
        sat = 1'b0;
        if (v > hi) begin v = hi; sat = 1'b1; end
        else if (v < 0) begin v = 0; sat = 1'b1; end
        return v[31:0];
    endfunction

    function automatic logic [31:0] ref_dbl(input logic [31:0] x, output bit sat);
        longint v = longint'($signed(x));
        sat = 1'b1;
        if (v >= 64'sh4000_0000) return 32'h7FFF_FFFF;
        if (v <= -64'sh4000_0000) return 32'h8000_0000;
        sat = 1'b0;
        v = v * 2;
        return v[31:0];
    endfunction

    // apply one op, check result and flag, then idle with clear and check again
    task automatic apply(input string req, input logic [3:0] o, input logic [31:0] x,
                         input logic [31:0] y, input logic [4:0] p,
                         input logic [31:0] exp_res, input bit exp_sat);
        @(negedge clk);
        op = o; a = x; b = y; pos = p; clr = 1'b0;
        @(negedge clk);
        check({req, " result"}, result, exp_res);
        check({req, " sticky"}, {31'd0, sticky}, {31'd0, exp_sat});
        op = 4'd0; clr = 1'b1;
        @(negedge clk);
        check("R11 cleared", {31'd0, sticky}, 32'd0);
        check("R12 idle holds result", result, exp_res);
        clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        bit s1, s2;
        logic [31:0] e, d;
        longint sa, sb, ua, ub;
        rst_n = 1'b0; op = 4'd0; a = '0; b = '0; pos = '0; clr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset result", result, 32'd0);
        check("R1 reset sticky", {31'd0, sticky}, 32'd0);
        rst_n = 1'b1;

        // two-operand operations over all corner pairs
        foreach (corners[i]) begin
            foreach (corners[j]) begin
                sa = longint'($signed(corners[i])); sb = longint'($signed(corners[j]));
                ua = longint'(corners[i]);          ub = longint'(corners[j]);
                e = ref_s(sa + sb, 31, s1);
                apply("R2", 4'd1, corners[i], corners[j], 5'd0, e, s1);
                e = ref_s(sa - sb, 31, s1);
                apply("R3", 4'd2, corners[i], corners[j], 5'd0, e, s1);
                void'(ref_s(sa + sb, 31, s1));
                apply("R4", 4'd3, corners[i], corners[j], 5'd0, corners[i] + corners[j], s1);
                d = ref_dbl(corners[j], s2);
                e = ref_s(sa + longint'($signed(d)), 31, s1);
                apply("R6", 4'd5, corners[i], corners[j], 5'd0, e, s1 | s2);
                e = ref_u(ua + ub, 32, s1);
                apply("R7 add", 4'd6, corners[i], corners[j], 5'd0, e, s1);
                e = ref_u(ua - ub, 32, s1);
                apply("R7 sub", 4'd7, corners[i], corners[j], 5'd0, e, s1);
            end
            e = ref_dbl(corners[i], s1);
            apply("R5", 4'd4, 32'h1357_9BDF, corners[i], 5'd0, e, s1);
        end

        // clamp operations over every position
        for (int p = 0; p < 32; p++) begin
            foreach (corners[i]) begin
                sa = longint'($signed(corners[i]));
                e = ref_s(sa, p, s1);
                apply("R8", 4'd8, corners[i], 32'd0, 5'(p), e, s1);
                e = ref_u(sa, p, s1);
                apply("R9", 4'd9, corners[i], 32'd0, 5'(p), e, s1);
                e[15:0]  = ref_s(longint'($signed(corners[i][15:0])), p, s1) & 32'hFFFF;
                e[31:16] = ref_s(longint'($signed(corners[i][31:16])), p, s2) & 32'hFFFF;
                apply("R10 signed", 4'd10, corners[i], 32'd0, 5'(p), e, s1 | s2);
                e[15:0]  = ref_u(longint'($signed(corners[i][15:0])), p, s1) & 32'hFFFF;
                e[31:16] = ref_u(longint'($signed(corners[i][31:16])), p, s2) & 32'hFFFF;
                apply("R10 unsigned", 4'd11, corners[i], 32'd0, 5'(p), e, s1 | s2);
            end
        end

        // clear in the same cycle as a saturating add
        @(negedge clk);
        op = 4'd1; a = 32'h7FFF_FFFF; b = 32'd1; clr = 1'b1;
        @(negedge clk);
        check("R11 clear wins result", result, 32'h7FFF_FFFF);
        check("R11 clear wins sticky", {31'd0, sticky}, 32'd0);

        // flag persists through a later non-saturating op and an unused code
        op = 4'd1; a = 32'h8000_0000; b = 32'hFFFF_FFFF; clr = 1'b0;
        @(negedge clk);
        check("R2 negative clamp", result, 32'h8000_0000);
        check("R11 set", {31'd0, sticky}, 32'd1);
        op = 4'd1; a = 32'd1; b = 32'd1;
        @(negedge clk);
        check("R11 kept result", result, 32'd2);
        check("R11 kept sticky", {31'd0, sticky}, 32'd1);
        op = 4'd13; a = 32'h7FFF_FFFF; b = 32'h7FFF_FFFF;
        @(negedge clk);
        check("R12 unused code result", result, 32'd2);
        check("R12 unused code sticky", {31'd0, sticky}, 32'd1);
        op = 4'd0;

        finish_run();
    end

endmodule